// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers 39 maskable interrupt requests from on-chip peripherals and keeps a pending flag for each of them. A per-source enable masks each flag. A fixed-priority arbiter then picks the winning source and drives three outputs to the CPU: an interrupt request, the winner's vector number, and the address of its vector slot in a table whose base software can move. The vector numbers are sparse: they run from 16 to 71 and skip a set of reserved holes.

The eight port-input sources each select one of four sensitivities. The two key-input sources each select an edge direction. Every other source sets its flag in any cycle its request line is high. A source that has a DMA channel can be steered to that channel with a per-source select bit. Its events then pulse a numbered trigger line instead of reaching the CPU. Software programs the controller through a simple word-addressed register bus. Read data is combinational.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Reset clears the table base and all enable, DMA-select, mode and pending bits. After reset, irq_req is 0, vec_num is 0, vec_addr is 0 and dma_trig is 0.
- R2: Source sN (input bit irq_src[N-1]) has one vector number. s1–s11 map to 16–26. s12–s23 map to 30,31,34,35,38,39,42,43,46,47,50,51. s24–s30 map to 52–58. s31–s33 map to 60–62. s34–s35 map to 64–65. s36–s39 map to 68–71. The numbers 27–29, 32–33, 36–37, 40–41, 44–45, 48–49, 59, 63 and 66–67 are never output, and vec_num is 0 while irq_req is 0.
- R3: vec_addr equals the base plus 4 × vec_num. The base sits at register 0. Only bits 31:10 of the base are writable, and bits 9:0 read back as 0.
- R4: The lowest-numbered candidate wins. s1 is the highest priority and s39 the lowest.
- R5: The port sources s1–s4 and s36–s39 take a 2-bit mode in register 7. Port slot k (s1..s4 = 0..3, s36..s39 = 4..7) uses bits [2k+1:2k]. The encodings are 00 rising edge, 01 falling edge, 10 high level and 11 low level.
- R6: Key sources s5 and s6 use register 7 bits 16 and 17 (0 = rising edge, 1 = falling edge). The opposite edge and a steady level never set their flag.
- R7: Edge and plain sources set their flag one clock after the event. Writing 1 to a flag bit clears it: register 1 bit k holds s(k+1), and register 2 bits 6:0 hold s33–s39. A new event in the same cycle beats the clear.
- R8: A level-mode flag follows its level condition with one clock of delay, and writing 1 to clear it has no effect.
- R9: Enables (register 3 = s1–s32, register 4 bits 6:0 = s33–s39) mask CPU candidacy only. A pending flag that is not enabled still reads back, and it asserts irq_req as soon as it is enabled.
- R10: With DMA-select set (register 5 = s1–s32, register 6 bits 6:0 = s33–s39) on a source that has a channel, each event of that source pulses dma_trig[ch] one clock later if the source is enabled, and its pending flag stays 0. DMA-select is ignored on a source without a channel. dma_trig[0] is always 0.
- R11: The channel map is: s1–s4 → 1–4, s7–s8 → 5–6, s12–s27 → 7–22, s29–s30 → 23–24, s32–s33 → 25–26, s34 → 27, s36–s39 → 28–31. No other source has a channel.
- R12: irq_req, vec_num and vec_addr are combinational from the pending, enable and base state. They show a new winner in the same cycle that the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 39 | Request lines, bit N-1 is source sN |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 3 | Word register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_req | output | 1 | Some enabled, CPU-routed source is pending |
| vec_num | output | 7 | Winning vector number, 0 when idle |
| vec_addr | output | 32 | Table base plus 4 × vec_num |
| dma_trig | output | 32 | One-cycle DMA channel triggers, bit = channel |

## Verification
The assertions check on every cycle that an issued vector lies within 16–71 and avoids every reserved hole. They also check that the vector address keeps the table alignment and carries the vector in bits 9:2, that an idle controller reports vector 0, and that channel 0 never triggers. Only the bench scenarios can show the source-to-vector and source-to-channel maps, the priority order, each port and key sensitivity, that a set beats a clear, that level flags ignore clears, and that enables mask a flag without losing it.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC  = 39;
  localparam int VEC_W = 7;
  localparam int CH_W  = 5;
  localparam int NCH   = 1 << CH_W;

  typedef enum logic [1:0] {
    SK_PORT  = 2'd0,
    SK_KEY   = 2'd1,
    SK_PLAIN = 2'd2
  } src_kind_e;

  typedef enum logic [1:0] {
    TM_RISE = 2'b00,
    TM_FALL = 2'b01,
    TM_HIGH = 2'b10,
    TM_LOW  = 2'b11
  } trig_mode_e;

  // i is the 0-based source index
  function automatic src_kind_e kind_of(input int i);
    if (i < 4 || i >= 35) return SK_PORT;
    if (i == 4 || i == 5) return SK_KEY;
    return SK_PLAIN;
  endfunction

  function automatic int port_slot(input int i);
    return (i < 4) ? i : i - 31;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input int i);
    int v;
    if (i <= 10)      v = 16 + i;
    else if (i <= 22) v = 30 + ((i - 11) / 2) * 4 + ((i - 11) % 2);
    else if (i <= 29) v = 52 + (i - 23);
    else if (i <= 32) v = 60 + (i - 30);
    else if (i <= 34) v = 64 + (i - 33);
    else              v = 68 + (i - 35);
    return VEC_W'(v);
  endfunction

  function automatic logic [CH_W-1:0] chan_of(input int i);
    int c;
    if (i <= 3)       c = i + 1;
    else if (i <= 5)  c = 0;
    else if (i <= 7)  c = i - 1;
    else if (i <= 10) c = 0;
    else if (i <= 26) c = i - 4;
    else if (i == 27) c = 0;
    else if (i <= 29) c = i - 5;
    else if (i == 30) c = 0;
    else if (i <= 32) c = i - 6;
    else if (i == 33) c = 27;
    else if (i == 34) c = 0;
    else              c = i - 7;
    return CH_W'(c);
  endfunction
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter irq_vec_pkg::src_kind_e KIND = irq_vec_pkg::SK_PLAIN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [1:0] mode,
  output logic       evt,
  output logic       is_level
);
  import irq_vec_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= din;
  end

  generate
    if (KIND == SK_PORT) begin : g_port
      always_comb begin
        unique case (trig_mode_e'(mode))
          TM_RISE: evt = din & ~prev_q;
          TM_FALL: evt = ~din & prev_q;
          TM_HIGH: evt = din;
          default: evt = ~din;
        endcase
        is_level = mode[1];
      end
    end else if (KIND == SK_KEY) begin : g_key
      always_comb begin
        evt      = mode[0] ? (~din & prev_q) : (din & ~prev_q);
        is_level = 1'b0;
      end
    end else begin : g_plain
      always_comb begin
        evt      = din;
        is_level = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NSRC   = irq_vec_pkg::NSRC,
  parameter int ADDR_W = 32
) (
  input  logic [NSRC-1:0]               cand,
  input  logic [ADDR_W-1:0]             base,
  output logic                          req,
  output logic [irq_vec_pkg::VEC_W-1:0] vec,
  output logic [ADDR_W-1:0]             addr
);
  import irq_vec_pkg::*;

  always_comb begin
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) vec = vec_of(i);
    end
    req  = |cand;
    addr = base + (ADDR_W'(vec) << 2);
  end
endmodule

// File: rtl/irq_dma_route.sv
module irq_dma_route #(
  parameter int NSRC = irq_vec_pkg::NSRC,
  parameter int NCH  = irq_vec_pkg::NCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] fire,
  output logic [NCH-1:0]  trig
);
  import irq_vec_pkg::*;

  logic [NCH-1:0] trig_d;

  always_comb begin
    trig_d = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (fire[i]) trig_d[chan_of(i)] = 1'b1;
    end
    trig_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) trig <= '0;
    else     trig <= trig_d;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int DATA_W   = 32,
  parameter int BUS_AW   = 3,
  parameter int BASE_LSB = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [irq_vec_pkg::NSRC-1:0]  irq_src,
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [BUS_AW-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          irq_req,
  output logic [irq_vec_pkg::VEC_W-1:0] vec_num,
  output logic [DATA_W-1:0]             vec_addr,
  output logic [irq_vec_pkg::NCH-1:0]   dma_trig
);
  import irq_vec_pkg::*;

  localparam int HI_W   = NSRC - DATA_W;
  localparam int NPORT  = 8;
  localparam int MODE_W = 2 * NPORT + 2;
  localparam int KEY_LSB = 2 * NPORT;

  localparam logic [BUS_AW-1:0] RA_BASE = 3'd0, RA_PLO = 3'd1, RA_PHI = 3'd2,
                                RA_ELO  = 3'd3, RA_EHI = 3'd4, RA_DLO = 3'd5,
                                RA_DHI  = 3'd6, RA_MODE = 3'd7;

  logic [DATA_W-1:BASE_LSB] base_q;
  logic [NSRC-1:0]          en_q, dsel_q, pend_q;
  logic [MODE_W-1:0]        mode_q;

  logic            wr;
  logic [NSRC-1:0] clr, evt, lvl, route, has_chan, fire;

  assign wr  = bus_sel & bus_we;
  assign clr = {(wr && bus_addr == RA_PHI) ? bus_wdata[HI_W-1:0] : {HI_W{1'b0}},
                (wr && bus_addr == RA_PLO) ? bus_wdata : {DATA_W{1'b0}}};

  // per-source detection, variant chosen by source kind
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [1:0] m;
      if (kind_of(i) == SK_PORT) begin : g_pm
        assign m = mode_q[2*port_slot(i) +: 2];
      end else if (kind_of(i) == SK_KEY) begin : g_km
        assign m = {1'b0, mode_q[KEY_LSB + i - 4]};
      end else begin : g_nm
        assign m = 2'b00;
      end
      irq_src_detect #(.KIND(kind_of(i))) u_det (
        .clk(clk), .rst(rst), .din(irq_src[i]), .mode(m),
        .evt(evt[i]), .is_level(lvl[i])
      );
      assign has_chan[i] = (chan_of(i) != '0);
    end
  endgenerate

  assign route = dsel_q & has_chan;
  assign fire  = route & en_q & evt;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      en_q   <= '0;
      dsel_q <= '0;
      mode_q <= '0;
    end else if (wr) begin
      unique case (bus_addr)
        RA_BASE: base_q            <= bus_wdata[DATA_W-1:BASE_LSB];
        RA_ELO:  en_q[DATA_W-1:0]  <= bus_wdata;
        RA_EHI:  en_q[NSRC-1:DATA_W] <= bus_wdata[HI_W-1:0];
        RA_DLO:  dsel_q[DATA_W-1:0]  <= bus_wdata;
        RA_DHI:  dsel_q[NSRC-1:DATA_W] <= bus_wdata[HI_W-1:0];
        RA_MODE: mode_q            <= bus_wdata[MODE_W-1:0];
        default: ;
      endcase
    end
  end

  // pending flags
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (route[i])    pend_q[i] <= 1'b0;
        else if (lvl[i]) pend_q[i] <= evt[i];
        else             pend_q[i] <= (pend_q[i] & ~clr[i]) | evt[i];
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_BASE: bus_rdata = {base_q, {BASE_LSB{1'b0}}};
      RA_PLO:  bus_rdata = pend_q[DATA_W-1:0];
      RA_PHI:  bus_rdata = DATA_W'(pend_q[NSRC-1:DATA_W]);
      RA_ELO:  bus_rdata = en_q[DATA_W-1:0];
      RA_EHI:  bus_rdata = DATA_W'(en_q[NSRC-1:DATA_W]);
      RA_DLO:  bus_rdata = dsel_q[DATA_W-1:0];
      RA_DHI:  bus_rdata = DATA_W'(dsel_q[NSRC-1:DATA_W]);
      default: bus_rdata = DATA_W'(mode_q);
    endcase
  end

  irq_prio_arb #(.NSRC(NSRC), .ADDR_W(DATA_W)) u_arb (
    .cand(pend_q & en_q),
    .base({base_q, {BASE_LSB{1'b0}}}),
    .req(irq_req), .vec(vec_num), .addr(vec_addr)
  );

  irq_dma_route #(.NSRC(NSRC), .NCH(NCH)) u_dma (
    .clk(clk), .rst(rst), .fire(fire), .trig(dma_trig)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq_req,
  input logic [6:0]  vec_num,
  input logic [31:0] vec_addr,
  input logic [31:0] dma_trig
);
  a_r2_vec_in_range: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (vec_num >= 7'd16 && vec_num <= 7'd71));

  a_r2_no_reserved: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !(vec_num inside {7'd27, 7'd28, 7'd29, 7'd32, 7'd33, 7'd36, 7'd37,
                                  7'd40, 7'd41, 7'd44, 7'd45, 7'd48, 7'd49,
                                  7'd59, 7'd63, 7'd66, 7'd67}));

  a_r2_idle_vec_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (vec_num == 7'd0));

  a_r3_addr_slot: assert property (@(posedge clk) disable iff (rst)
    (vec_addr[1:0] == 2'b00) && (vec_addr[9:2] == {1'b0, vec_num}));

  a_r10_chan0_idle: assert property (@(posedge clk) disable iff (rst)
    dma_trig[0] == 1'b0);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_req && dma_trig == 32'd0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (.*);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1400;

  localparam int EXP_VEC [39] = '{16,17,18,19,20,21,22,23,24,25,26,
                                  30,31,34,35,38,39,42,43,46,47,50,51,
                                  52,53,54,55,56,57,58,60,61,62,64,65,
                                  68,69,70,71};
  localparam int EXP_CH [39]  = '{1,2,3,4,0,0,5,6,0,0,0,
                                  7,8,9,10,11,12,13,14,15,16,17,18,19,20,21,22,
                                  0,23,24,0,25,26,27,0,28,29,30,31};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [38:0] irq_src = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, vec_addr, dma_trig;
  logic        irq_req;
  logic [6:0]  vec_num;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  typedef struct {
    int          id;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .vec_num(vec_num), .vec_addr(vec_addr), .dma_trig(dma_trig)
  );

  // scoreboard monitor: compares queued expectations after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic [31:0] act;
        e = q.pop_front();
        case (e.id)
          0:       act = {31'd0, irq_req};
          1:       act = {25'd0, vec_num};
          2:       act = vec_addr;
          3:       act = bus_rdata;
          default: act = dma_trig;
        endcase
        checks++;
        if (act !== e.val) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.val);
        end
      end
    end
  end

  task automatic expect_val(input int id, input logic [31:0] v, input string tag);
    exp_t e;
    e.id = id; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] v, input string tag);
    bus_addr = a;
    expect_val(3, v, tag);
    #3;
  endtask

  task automatic clear_src(input int i);
    if (i < 32) bus_write(3'd1, 32'd1 << i);
    else        bus_write(3'd2, 32'd1 << (i - 32));
  endtask

  task automatic pulse_src(input int i);
    tick();
    irq_src[i] = 1'b1;
    tick();
    irq_src[i] = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    expect_val(0, 0, "R1 irq_req");
    expect_val(1, 0, "R1 vec_num");
    expect_val(2, 0, "R1 vec_addr");
    expect_val(4, 0, "R1 dma_trig");
    rd(3'd0, 0, "R1 base");
    rd(3'd1, 0, "R1 pending lo");
    rd(3'd3, 0, "R1 enable lo");
    rd(3'd7, 0, "R1 mode");

    // R3 base alignment
    bus_write(3'd0, BASE | 32'h3FF);
    rd(3'd0, BASE, "R3 base low bits");
    bus_write(3'd3, 32'hFFFF_FFFF);
    bus_write(3'd4, 32'h7F);

    // R2/R3 sweep of all sources to the CPU
    for (int i = 0; i < 39; i++) begin
      pulse_src(i);
      expect_val(0, 1, "R2 irq_req sweep");
      expect_val(1, EXP_VEC[i], "R2 vec_num sweep");
      expect_val(2, BASE + 4 * EXP_VEC[i], "R3 vec_addr sweep");
      clear_src(i);
      expect_val(0, 0, "R7 cleared sweep");
    end

    // R10/R11 sweep with DMA-select on every source
    bus_write(3'd5, 32'hFFFF_FFFF);
    bus_write(3'd6, 32'h7F);
    for (int i = 0; i < 39; i++) begin
      pulse_src(i);
      if (EXP_CH[i] != 0) begin
        expect_val(4, 32'd1 << EXP_CH[i], "R11 dma channel");
        expect_val(0, 0, "R10 no cpu request when routed");
        tick();
        expect_val(4, 0, "R10 single pulse");
      end else begin
        expect_val(4, 0, "R10 no channel no trigger");
        expect_val(1, EXP_VEC[i], "R10 select ignored without channel");
        clear_src(i);
      end
    end
    bus_write(3'd5, 0);
    bus_write(3'd6, 0);

    // R4/R12 priority and same-cycle update
    tick();
    irq_src[8] = 1'b1; irq_src[19] = 1'b1;
    tick();
    irq_src[8] = 1'b0; irq_src[19] = 1'b0;
    expect_val(1, 24, "R4 s9 beats s20");
    expect_val(2, BASE + 32'h60, "R4 addr s9");
    clear_src(8);
    expect_val(1, 46, "R12 next winner s20");
    expect_val(2, BASE + 32'hB8, "R12 addr s20");
    clear_src(19);
    expect_val(0, 0, "R4 idle");

    // R9 enable masking
    bus_write(3'd3, 32'hFFFF_FEFF);
    pulse_src(8);
    expect_val(0, 0, "R9 masked");
    rd(3'd1, 32'h100, "R9 pending kept");
    bus_write(3'd3, 32'hFFFF_FFFF);
    expect_val(1, 24, "R9 unmasked");
    clear_src(8);

    // R7 set beats clear
    tick();
    irq_src[9] = 1'b1;
    clear_src(9);
    rd(3'd1, 32'h200, "R7 set wins over clear");
    irq_src[9] = 1'b0;
    clear_src(9);
    rd(3'd1, 0, "R7 clear");

    // R5 falling edge on s1
    bus_write(3'd7, 32'h1);
    tick(); irq_src[0] = 1'b1;
    tick(); tick();
    expect_val(0, 0, "R5 rising ignored in fall mode");
    irq_src[0] = 1'b0;
    tick();
    expect_val(1, 16, "R5 falling edge s1");
    clear_src(0);

    // R5/R8 high level on s2
    bus_write(3'd7, 32'h8);
    tick(); irq_src[1] = 1'b1;
    tick();
    expect_val(1, 17, "R5 high level s2");
    clear_src(1);
    rd(3'd1, 32'h2, "R8 clear ignored on level");
    irq_src[1] = 1'b0;
    tick();
    expect_val(0, 0, "R8 level released");

    // R5 low level on s36 (slot 4)
    bus_write(3'd7, 32'h300);
    tick();
    expect_val(1, 68, "R5 low level s36");
    irq_src[35] = 1'b1;
    tick();
    expect_val(0, 0, "R8 low level released");
    bus_write(3'd7, 32'h0);
    irq_src[35] = 1'b0;

    // R6 key falling edge on s6
    bus_write(3'd7, 32'h2_0000);
    tick(); irq_src[5] = 1'b1;
    tick(); tick();
    expect_val(0, 0, "R6 rising ignored on falling key");
    irq_src[5] = 1'b0;
    tick();
    expect_val(1, 21, "R6 key falling s6");
    clear_src(5);
    tick(); tick();
    expect_val(0, 0, "R6 no level on key");

    tick();
    #3;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule